// File: doc/BRIEF.md
# Exception Return Decision Controller

This block decides where a small processor core goes next when an interrupt service routine finishes. It keeps a set of pending exception requests and a nesting stack of active handlers, each recorded with its priority and exception number. While a handler or thread code runs, a pending request that outranks the running context causes a preemption: the block pulses an entry indication, records the new handler on the stack and clears its pending bit.

When the core signals an exception return, the block removes the finishing handler from the stack. One cycle later it compares the best pending request against the handler now on top of the stack. If the pending request outranks it, or if the stack is empty, the block tail-chains straight into the pending handler. A tail-chain needs no register restore. Otherwise it restores context by issuing eight 32-bit reads from the saved stack pointer upward. It then reports the new stack pointer and either a return to the stacked handler or a return to thread code. While those reads are in progress, a newly eligible pending request abandons the remaining reads and turns the return into a tail-chain.

The read requests use valid/ready. `rd_valid_o` and `rd_addr_o` stay steady until `rd_ready_i` accepts them, and the stall can last any number of cycles. The only case where a request is withdrawn without being accepted is a tail-chain abort. The other pins are plain single-cycle strobes.

Top module: `erd_ctrl`

## Requirements
- R1: After reset the stack is empty, nothing is pending, and `enter_o`, `rd_valid_o`, `done_o`, `outc_valid_o` and `ovf_o` are all 0.
- R2: Exception n takes its priority from `exc_prio_i[3n+2:3n]`. A lower value means higher priority. Among pending requests of equal priority, the lowest exception number is chosen.
- R3: When no return is in progress, a pending request preempts if it has strictly higher priority than the top of the stack, or if the stack is empty. `enter_o` is then high for one cycle with `enter_num_o` set, the request is pushed, and its pending bit is cleared. A request of equal priority does not preempt.
- R4: If, in the cycle after `exc_ret_i`, the best pending request outranks the new stack top or the stack is empty, `outc_code_o`=2'b10 (tail-chain) is reported in that same cycle with the pending number, and no read is issued.
- R5: If no tail-chain happens and the stack is not empty, the eight reads complete and then `outc_code_o`=2'b01 (stacked-handler return) is reported with the stacked handler's number.
- R6: If the stack is empty and nothing is pending, the eight reads complete and then `outc_code_o`=2'b00 (thread return) is reported with number 0.
- R7: The k-th read (k=0..7) addresses `sp_i`+4k, where `sp_i` is sampled with `exc_ret_i`. Under back-pressure the request is held unchanged.
- R8: `done_o` pulses in the cycle of the eighth accepted read, together with `sp_new_o` = sampled SP + 32 and the outcome report.
- R9: If, during the reads, a pending request outranks the stack top (or the stack is empty), the remaining reads are dropped, `done_o` is not raised, and a tail-chain (2'b10) is reported with that number.
- R10: A push while the stack already holds DEPTH entries is dropped and sets `ovf_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_prio_i | input | 48 | Priority of each exception, 3 bits each |
| pend_set_i | input | 16 | One bit per exception; raises its pending request |
| exc_ret_i | input | 1 | Exception-return strobe from the core |
| sp_i | input | 32 | Stack pointer, sampled with the return strobe |
| rd_ready_i | input | 1 | Memory accepts the current read request |
| enter_o | output | 1 | Preemption into a pending handler |
| enter_num_o | output | 4 | Exception number being entered |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | 32 | Read address |
| done_o | output | 1 | Register restore finished |
| sp_new_o | output | 32 | Stack pointer after restore |
| outc_valid_o | output | 1 | Return outcome valid (one cycle) |
| outc_code_o | output | 2 | 00 thread, 01 stacked handler, 10 tail-chain |
| outc_num_o | output | 4 | Target exception number |
| ovf_o | output | 1 | Sticky nesting-stack overflow |

## Verification
A register restore and the arrival of an outranking pending request can land in the same cycle. When that happens, the block must give up the read it is still presenting instead of letting it complete. The bench provokes this by holding `rd_ready_i` low during a restore from the last handler and raising a request mid-sequence. It then checks that no read is accepted, that `done_o` never rises, and that exactly one tail-chain outcome names the new request.

// File: rtl/erd_pkg.sv
package erd_pkg;
  typedef enum logic [1:0] {
    OUT_THREAD  = 2'b00,
    OUT_STACKED = 2'b01,
    OUT_CHAIN   = 2'b10
  } outcome_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_DECIDE,
    S_POP
  } state_e;
endpackage

// File: rtl/erd_pick.sv
module erd_pick #(
  parameter int NUM_EXC = 16,
  parameter int PRIO_W  = 3,
  localparam int NUM_W  = $clog2(NUM_EXC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_EXC-1:0]        pend_i,
  input  logic [NUM_EXC*PRIO_W-1:0] prio_i,
  output logic                      valid_o,
  output logic [NUM_W-1:0]          num_o,
  output logic [PRIO_W-1:0]         prio_o
);
  // descending scan with <= lets the lower number win a tie
  always_comb begin
    valid_o = 1'b0;
    num_o   = '0;
    prio_o  = '1;
    for (int i = NUM_EXC - 1; i >= 0; i--) begin
      if (pend_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] <= prio_o)) begin
        valid_o = 1'b1;
        num_o   = NUM_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  a_r2_pick_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> pend_i[num_o]);
endmodule

// File: rtl/erd_stack.sv
module erd_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int NUM_W  = 4,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic [NUM_W-1:0]  push_num_i,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [PRIO_W-1:0] top_prio_o,
  output logic [NUM_W-1:0]  top_num_o,
  output logic              ovf_o
);
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [NUM_W-1:0]  num_q  [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     top_idx;

  assign empty_o    = (cnt_q == '0);
  assign top_idx    = IW'(cnt_q - 1'b1);
  assign top_prio_o = empty_o ? '1 : prio_q[top_idx];
  assign top_num_o  = empty_o ? '0 : num_q[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else if (push_i) begin
      if (cnt_q == CW'(DEPTH)) begin
        ovf_o <= 1'b1;
      end else begin
        prio_q[IW'(cnt_q)] <= push_prio_i;
        num_q[IW'(cnt_q)]  <= push_num_i;
        cnt_q              <= cnt_q + 1'b1;
      end
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/erd_popseq.sv
module erd_popseq #(
  parameter int AW   = 32,
  parameter int NREG = 8,
  localparam int CW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic          abort_i,
  input  logic          rd_ready_i,
  output logic          rd_valid_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          done_o,
  output logic [AW-1:0] sp_new_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] base_q;
  logic          last;

  assign last       = (cnt_q == CW'(NREG - 1));
  assign rd_valid_o = busy_q && !abort_i;
  assign rd_addr_o  = base_q + (AW'(cnt_q) << 2);
  assign done_o     = rd_valid_o && rd_ready_i && last;
  assign sp_new_o   = base_q + AW'(NREG * 4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        base_q <= base_i;
      end
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (rd_ready_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> $stable(rd_addr_o));
  a_r8_done_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rd_valid_o && rd_ready_i));
  a_r9_abort_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |-> !rd_valid_o);
endmodule

// File: rtl/erd_ctrl.sv
module erd_ctrl #(
  parameter int NUM_EXC = 16,
  parameter int PRIO_W  = 3,
  parameter int DEPTH   = 8,
  parameter int AW      = 32,
  parameter int NREG    = 8,
  localparam int NUM_W  = $clog2(NUM_EXC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_EXC*PRIO_W-1:0] exc_prio_i,
  input  logic [NUM_EXC-1:0]        pend_set_i,
  input  logic                      exc_ret_i,
  input  logic [AW-1:0]             sp_i,
  input  logic                      rd_ready_i,
  output logic                      enter_o,
  output logic [NUM_W-1:0]          enter_num_o,
  output logic                      rd_valid_o,
  output logic [AW-1:0]             rd_addr_o,
  output logic                      done_o,
  output logic [AW-1:0]             sp_new_o,
  output logic                      outc_valid_o,
  output logic [1:0]                outc_code_o,
  output logic [NUM_W-1:0]          outc_num_o,
  output logic                      ovf_o
);
  import erd_pkg::*;

  state_e             state_q;
  logic [NUM_EXC-1:0] pend_q;
  logic [AW-1:0]      sp_q;
  logic               pick_v;
  logic [NUM_W-1:0]   pick_num;
  logic [PRIO_W-1:0]  pick_prio;
  logic               stk_empty;
  logic [PRIO_W-1:0]  top_prio;
  logic [NUM_W-1:0]   top_num;
  logic               win;
  logic               take;
  logic               ret_now;
  logic [NUM_EXC-1:0] clr;
  outcome_e           code;

  erd_pick #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_q), .prio_i(exc_prio_i),
    .valid_o(pick_v), .num_o(pick_num), .prio_o(pick_prio)
  );

  erd_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .NUM_W(NUM_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(take), .push_prio_i(pick_prio),
    .push_num_i(pick_num), .pop_i(ret_now), .empty_o(stk_empty),
    .top_prio_o(top_prio), .top_num_o(top_num), .ovf_o(ovf_o)
  );

  erd_popseq #(.AW(AW), .NREG(NREG)) u_pop (
    .clk(clk), .rst_n(rst_n), .start_i(state_q == S_DECIDE && !win),
    .base_i(sp_q), .abort_i(state_q == S_POP && win),
    .rd_ready_i(rd_ready_i), .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o),
    .done_o(done_o), .sp_new_o(sp_new_o)
  );

  // one comparison serves preemption, tail-chain and abort
  assign win     = pick_v && (stk_empty || pick_prio < top_prio);
  assign ret_now = (state_q == S_IDLE) && exc_ret_i;
  assign take    = win && !ret_now;
  assign clr     = take ? (NUM_EXC'(1) << pick_num) : '0;

  assign enter_o     = take && (state_q == S_IDLE);
  assign enter_num_o = pick_num;

  always_comb begin
    if (take) code = OUT_CHAIN;
    else if (stk_empty) code = OUT_THREAD;
    else code = OUT_STACKED;
  end

  assign outc_valid_o = (take && state_q != S_IDLE) || done_o;
  assign outc_code_o  = code;
  assign outc_num_o   = take ? pick_num : top_num;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pend_q  <= '0;
      sp_q    <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | pend_set_i;
      case (state_q)
        S_IDLE: if (ret_now) begin
          state_q <= S_DECIDE;
          sp_q    <= sp_i;
        end
        S_DECIDE: state_q <= win ? S_IDLE : S_POP;
        S_POP:    if (win || done_o) state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  a_r4_chain_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (outc_valid_o && outc_code_o == 2'b10) |-> !rd_valid_o);
  a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    outc_valid_o |-> (outc_code_o != 2'b11));
  a_r3_enter_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_o && !pend_set_i[enter_num_o]) |=> !pend_q[$past(enter_num_o)]);
  a_r3_enter_not_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> !outc_valid_o);
endmodule

// File: tb/sim_erd_ctrl.sv
module sim_erd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] exc_prio_i = '1;
  logic [15:0] pend_set_i = '0;
  logic        exc_ret_i = 1'b0;
  logic [31:0] sp_i = '0;
  logic        rd_ready_i = 1'b0;
  logic        enter_o;
  logic [3:0]  enter_num_o;
  logic        rd_valid_o;
  logic [31:0] rd_addr_o;
  logic        done_o;
  logic [31:0] sp_new_o;
  logic        outc_valid_o;
  logic [1:0]  outc_code_o;
  logic [3:0]  outc_num_o;
  logic        ovf_o;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  erd_ctrl #(.DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .exc_prio_i(exc_prio_i), .pend_set_i(pend_set_i),
    .exc_ret_i(exc_ret_i), .sp_i(sp_i), .rd_ready_i(rd_ready_i),
    .enter_o(enter_o), .enter_num_o(enter_num_o), .rd_valid_o(rd_valid_o),
    .rd_addr_o(rd_addr_o), .done_o(done_o), .sp_new_o(sp_new_o),
    .outc_valid_o(outc_valid_o), .outc_code_o(outc_code_o),
    .outc_num_o(outc_num_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_prio(input int n, input logic [2:0] p);
    exc_prio_i[n*3 +: 3] = p;
  endtask

  task automatic pulse_set(input logic [15:0] mask);
    @(negedge clk) pend_set_i = mask;
    @(negedge clk) pend_set_i = '0;
    #1;
  endtask

  task automatic do_ret(input logic [31:0] sp);
    @(negedge clk) begin exc_ret_i = 1'b1; sp_i = sp; end
    @(negedge clk) exc_ret_i = 1'b0;
  endtask

  // mode 1 ready high, 2 ready low, 3 ready alternating
  task automatic run_outcome(input int mode, input int inj, input int inj_num,
                             input logic [31:0] sp, output logic [1:0] code,
                             output logic [3:0] num, output int nrd, output int ndone);
    nrd = 0; ndone = 0; code = 2'b11; num = '0;
    for (int it = 0; it < 60; it++) begin
      pend_set_i = (it == inj) ? (16'(1) << inj_num) : '0;
      rd_ready_i = (mode == 1) ? 1'b1 : (mode == 3) ? it[0] : 1'b0;
      #1;
      if (rd_valid_o && rd_ready_i) begin
        chk("R7 read address", rd_addr_o, sp + 32'(4 * nrd));
        nrd++;
      end
      if (done_o) begin
        ndone++;
        chk("R8 new stack pointer", sp_new_o, sp + 32'd32);
        chk("R8 done on eighth read", 32'(nrd), 32'd8);
      end
      if (outc_valid_o) begin
        code = outc_code_o; num = outc_num_o;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    #1;
    chk("R1 enter idle", 32'(enter_o), 0);
    chk("R1 read idle", 32'(rd_valid_o), 0);
    chk("R1 outcome idle", 32'(outc_valid_o), 0);
    chk("R1 done idle", 32'(done_o), 0);
    chk("R1 overflow clear", 32'(ovf_o), 0);
  endtask

  task automatic t_preempt;
    set_prio(5, 3);
    pulse_set(16'(1) << 5);
    chk("R3 enter from thread", 32'(enter_o), 1);
    chk("R3 enter number", 32'(enter_num_o), 5);
    @(negedge clk) #1;
    chk("R3 pending cleared", 32'(enter_o), 0);
    set_prio(6, 3);
    pulse_set(16'(1) << 6);
    chk("R3 equal priority no preempt", 32'(enter_o), 0);
    set_prio(2, 1);
    pulse_set(16'(1) << 2);
    chk("R2 higher priority preempts", 32'(enter_o), 1);
    chk("R2 preempt number", 32'(enter_num_o), 2);
  endtask

  task automatic t_stacked;
    logic [1:0] c; logic [3:0] n; int r; int d;
    do_ret(32'h0000_1000);
    run_outcome(1, -1, 0, 32'h0000_1000, c, n, r, d);
    chk("R5 stacked code", 32'(c), 32'b01);
    chk("R5 stacked number", 32'(n), 5);
    chk("R5 eight reads", 32'(r), 8);
    chk("R8 one done", 32'(d), 1);
    @(negedge clk) #1;
    chk("R3 equal pending stays", 32'(enter_o), 0);
  endtask

  task automatic t_chain;
    logic [1:0] c; logic [3:0] n; int r; int d;
    do_ret(32'h0000_2000);
    run_outcome(1, -1, 0, 32'h0000_2000, c, n, r, d);
    chk("R4 chain code", 32'(c), 32'b10);
    chk("R4 chain number", 32'(n), 6);
    chk("R4 no reads", 32'(r), 0);
  endtask

  task automatic t_thread_bp;
    logic [1:0] c; logic [3:0] n; int r; int d;
    do_ret(32'h0000_3F00);
    run_outcome(3, -1, 0, 32'h0000_3F00, c, n, r, d);
    chk("R6 thread code", 32'(c), 32'b00);
    chk("R6 thread number", 32'(n), 0);
    chk("R7 reads under back-pressure", 32'(r), 8);
    chk("R8 done once", 32'(d), 1);
  endtask

  task automatic t_tie;
    logic [1:0] c; logic [3:0] n; int r; int d;
    set_prio(9, 2); set_prio(4, 2);
    pulse_set((16'(1) << 9) | (16'(1) << 4));
    chk("R2 tie enters", 32'(enter_o), 1);
    chk("R2 tie lower number", 32'(enter_num_o), 4);
    do_ret(32'h100);
    run_outcome(1, -1, 0, 32'h100, c, n, r, d);
    chk("R4 chain after tie", 32'(c), 32'b10);
    chk("R4 chain tie number", 32'(n), 9);
    @(negedge clk);
    do_ret(32'h200);
    run_outcome(1, -1, 0, 32'h200, c, n, r, d);
    chk("R6 thread after tie", 32'(c), 32'b00);
  endtask

  task automatic t_abort;
    logic [1:0] c; logic [3:0] n; int r; int d;
    set_prio(3, 4);
    pulse_set(16'(1) << 3);
    chk("R3 enter for abort", 32'(enter_num_o), 3);
    set_prio(7, 5);
    do_ret(32'h400);
    run_outcome(2, 2, 7, 32'h400, c, n, r, d);
    chk("R9 abort code", 32'(c), 32'b10);
    chk("R9 abort number", 32'(n), 7);
    chk("R9 no read accepted", 32'(r), 0);
    chk("R9 no done", 32'(d), 0);
    @(negedge clk);
    do_ret(32'h500);
    run_outcome(1, -1, 0, 32'h500, c, n, r, d);
    chk("R6 thread after abort", 32'(c), 32'b00);
    chk("R7 full reads after abort", 32'(r), 8);
  endtask

  task automatic t_overflow;
    for (int k = 0; k < 5; k++) begin
      set_prio(10 + k, 3'(6 - k));
      pulse_set(16'(1) << (10 + k));
      chk("R10 nested enter", 32'(enter_num_o), 32'(10 + k));
      if (k == 3) chk("R10 full not overflow", 32'(ovf_o), 0);
    end
    @(negedge clk) #1;
    chk("R10 overflow set", 32'(ovf_o), 1);
    repeat (3) @(negedge clk);
    #1;
    chk("R10 overflow sticky", 32'(ovf_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_preempt();
    t_stacked();
    t_chain();
    t_thread_bp();
    t_tie();
    t_abort();
    t_overflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule